// File: doc/BRIEF.md
# Code-Density Bin Compensation Calibrator

This block corrects the nonlinearity of a delay-line time-to-digital converter. Its input is a finished code-density histogram, where each raw fine code has collected a number of hits proportional to its real width in time. The block reads that histogram once through a plain address/data port and builds a remap table, one entry per raw code. At run time every raw code is turned into a corrected output bin by looking it up in the table.

For each raw bin the block forms the bin's start and end on the cumulative count axis. It compares those points with evenly spaced ideal boundaries. The ideal bin that holds the raw bin's start becomes the main bin. If the raw bin runs past the next ideal boundary, the following ideal bin becomes a compensation bin. The share of the raw bin that lies beyond that boundary is stored as a 16-bit fraction. At run time a 16-bit pseudo-random sequence is compared with this fraction, so that the right proportion of hits moves to the compensation bin.

A merge mode halves the number of ideal bins, so that each ideal bin is twice as wide. This absorbs very small and very wide raw bins before the compensation step. Raw bins with no counts produce no output. An ideal bin that no raw bin reaches stays empty; such missing codes are allowed.

Top module: `dcbc_calibrator`

## Requirements
- R1: After reset, cal_busy and cal_done are 0 and every raw code gives bin_valid = 0 until a calibration has finished.
- R2: cal_start sampled high in idle or done state sets cal_busy. The block reads addresses 0..N_RAW-1 once to total the histogram and a second time to build the table. cal_done goes high, and cal_busy low, on the 2·N_RAW-th rising edge after the edge that sampled cal_start. cal_done stays high until the next start.
- R3: With total count S, E ideal bins, and C_lo the sum of the counts of raw bins below k, the main bin of a non-empty raw bin k is floor(C_lo·E/S).
- R4: With C_hi = C_lo + h[k], raw bin k has a compensation bin, equal to main+1, only when C_hi·E > (main+1)·S. Otherwise every hit on k is sent to its main bin.
- R5: The compensation fraction is floor((C_hi·E − (main+1)·S)·65536 / (h[k]·E)).
- R6: A raw code whose histogram count is 0 never gives bin_valid = 1.
- R7: merge_mode, sampled with cal_start, sets E = N_OUT/2. Otherwise E = N_OUT. Output bins then lie in 0..E−1.
- R8: The dither value is a 16-bit right-shifting Galois sequence with seed 0xACE1; when the LSB is 1 the shifted value is XORed with 0xB400. It advances once per cycle in which code_valid is high. A hit goes to the compensation bin exactly when one exists and the dither value before that advance is below the fraction.
- R9: bin_valid and bin_out follow code_valid and code_in by one clock. bin_valid is 0 in any cycle after one with code_valid low.
- R10: cal_start is ignored while cal_busy is high; the calibration in progress keeps its timing.
- R11: For an uneven histogram, replaying the hits through the table gives an output histogram whose max-minus-min spread is smaller than that of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Begin building the table |
| merge_mode | input | 1 | Pair ideal bins (sampled with cal_start) |
| cal_busy | output | 1 | Table build in progress |
| cal_done | output | 1 | Table complete |
| hist_addr | output | $clog2(N_RAW) | Histogram read address |
| hist_rdata | input | CNT_W | Histogram count at hist_addr, same cycle |
| code_valid | input | 1 | Raw code present |
| code_in | input | $clog2(N_RAW) | Raw fine code |
| bin_valid | output | 1 | Corrected bin present |
| bin_out | output | $clog2(N_OUT) | Corrected output bin |

## Verification
The bench builds the block with N_RAW = 16, N_OUT = 16 and CNT_W = 12. With these values a whole table can be checked entry by entry in a few hundred cycles, and a 1600-count histogram gives ideal bins exactly 100 counts wide. That histogram has empty bins, a bin three ideal widths wide, and boundaries that fall exactly on ideal edges, so missing codes, the "no compensation at equality" rule and large fractions can all be reached. Merge mode with E = 8 and seeded random histograms cover the remaining fraction values and bin offsets.

// File: rtl/dcbc_pkg.sv
package dcbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SUM,
    ST_SCAN,
    ST_DONE
  } cal_state_e;

  localparam int FRAC_W = 16;
  typedef logic [FRAC_W-1:0] frac_t;

  localparam frac_t DITHER_SEED = 16'hACE1;
  localparam frac_t DITHER_TAPS = 16'hB400;

  // one step of the right-shifting Galois dither sequence
  function automatic frac_t dither_step(frac_t s);
    return s[0] ? ((s >> 1) ^ DITHER_TAPS) : (s >> 1);
  endfunction

endpackage

// File: rtl/dcbc_lfsr.sv
module dcbc_lfsr
  import dcbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  output frac_t value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= DITHER_SEED;
    else if (step) value <= dither_step(value);
  end

endmodule

// File: rtl/dcbc_table_builder.sv
module dcbc_table_builder
  import dcbc_pkg::*;
#(
  parameter int N_RAW = 32,
  parameter int N_OUT = 32,
  parameter int CNT_W = 12,
  localparam int AW    = $clog2(N_RAW),
  localparam int OB_W  = $clog2(N_OUT),
  localparam int NE_W  = OB_W + 1,
  localparam int CUM_W = CNT_W + AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             merge,
  output logic             busy,
  output logic             done,
  output logic [AW-1:0]    rd_addr,
  input  logic [CNT_W-1:0] rd_data,
  output logic [NE_W-1:0]  neff,
  output logic             wr_en,
  output logic [AW-1:0]    wr_idx,
  output logic             wr_valid,
  output logic [OB_W-1:0]  wr_main,
  output logic             wr_comp_valid,
  output logic [OB_W-1:0]  wr_comp,
  output frac_t            wr_frac
);

  localparam int WW = CUM_W + NE_W + FRAC_W + 2;
  typedef logic [WW-1:0] wide_t;

  cal_state_e           state;
  logic [AW-1:0]        idx;
  logic [CUM_W-1:0]     total;
  logic [CUM_W-1:0]     cum;
  logic                 merge_q;
  logic [CUM_W-1:0]     cum_hi;
  logic                 last_idx;
  logic                 accept_start;

  // ideal bin holding a point on the cumulative axis (point scaled by E)
  function automatic logic [OB_W-1:0] f_main_bin(wide_t lo_scaled, wide_t tot);
    wide_t q;
    q = (tot == '0) ? '0 : (lo_scaled / tot);
    return q[OB_W-1:0];
  endfunction

  // scaled position of the ideal boundary that closes a given ideal bin
  function automatic wide_t f_bound(logic [OB_W-1:0] m, wide_t tot);
    return (wide_t'(m) + wide_t'(1)) * tot;
  endfunction

  // part of a raw bin past the boundary, as a 16-bit fraction of its width
  function automatic frac_t f_share(wide_t hi_scaled, wide_t bnd, wide_t den);
    wide_t q;
    if (den == '0 || hi_scaled <= bnd) return '0;
    q = ((hi_scaled - bnd) << FRAC_W) / den;
    return q[FRAC_W-1:0];
  endfunction

  assign neff         = merge_q ? NE_W'(N_OUT / 2) : NE_W'(N_OUT);
  assign cum_hi       = cum + CUM_W'(rd_data);
  assign last_idx     = (idx == AW'(N_RAW - 1));
  assign accept_start = start && (state == ST_IDLE || state == ST_DONE);
  assign rd_addr      = idx;
  assign busy         = (state == ST_SUM) || (state == ST_SCAN);
  assign done         = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      total   <= '0;
      cum     <= '0;
      merge_q <= 1'b0;
    end else begin
      case (state)
        ST_SUM: begin
          total <= total + CUM_W'(rd_data);
          if (last_idx) begin
            state <= ST_SCAN;
            idx   <= '0;
          end else begin
            idx <= idx + AW'(1);
          end
        end
        ST_SCAN: begin
          cum <= cum_hi;
          if (last_idx) state <= ST_DONE;
          else          idx   <= idx + AW'(1);
        end
        default: begin
          if (accept_start) begin
            state   <= ST_SUM;
            idx     <= '0;
            total   <= '0;
            cum     <= '0;
            merge_q <= merge;
          end
        end
      endcase
    end
  end

  // table entry for the raw bin being scanned
  wide_t lo_s, hi_s, tot_w, bnd_s, den_s;
  always_comb begin
    tot_w         = wide_t'(total);
    lo_s          = wide_t'(cum) * wide_t'(neff);
    hi_s          = wide_t'(cum_hi) * wide_t'(neff);
    den_s         = wide_t'(rd_data) * wide_t'(neff);
    wr_main       = f_main_bin(lo_s, tot_w);
    bnd_s         = f_bound(wr_main, tot_w);
    wr_valid      = (rd_data != '0) && (total != '0);
    wr_comp_valid = wr_valid && (hi_s > bnd_s);
    wr_comp       = wr_main + OB_W'(1);
    wr_frac       = wr_comp_valid ? f_share(hi_s, bnd_s, den_s) : '0;
  end

  assign wr_en  = (state == ST_SCAN);
  assign wr_idx = idx;

endmodule

// File: rtl/dcbc_remap.sv
module dcbc_remap
  import dcbc_pkg::*;
#(
  parameter int N_RAW = 32,
  parameter int N_OUT = 32,
  localparam int AW   = $clog2(N_RAW),
  localparam int OB_W = $clog2(N_OUT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic            wr_valid,
  input  logic [OB_W-1:0] wr_main,
  input  logic            wr_comp_valid,
  input  logic [OB_W-1:0] wr_comp,
  input  frac_t           wr_frac,
  input  frac_t           dither,
  input  logic            code_valid,
  input  logic [AW-1:0]   code_in,
  output logic            bin_valid,
  output logic [OB_W-1:0] bin_out
);

  logic            tbl_v    [N_RAW];
  logic            tbl_cv   [N_RAW];
  logic [OB_W-1:0] tbl_main [N_RAW];
  logic [OB_W-1:0] tbl_comp [N_RAW];
  frac_t           tbl_frac [N_RAW];

  logic take_comp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_RAW; i++) begin
        tbl_v[i]  <= 1'b0;
        tbl_cv[i] <= 1'b0;
      end
    end else if (wr_en) begin
      tbl_v[wr_idx]  <= wr_valid;
      tbl_cv[wr_idx] <= wr_comp_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tbl_main[wr_idx] <= wr_main;
      tbl_comp[wr_idx] <= wr_comp;
      tbl_frac[wr_idx] <= wr_frac;
    end
  end

  assign take_comp = tbl_cv[code_in] && (dither < tbl_frac[code_in]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_valid <= 1'b0;
      bin_out   <= '0;
    end else begin
      bin_valid <= code_valid && tbl_v[code_in];
      if (code_valid) bin_out <= take_comp ? tbl_comp[code_in] : tbl_main[code_in];
    end
  end

endmodule

// File: rtl/dcbc_calibrator.sv
module dcbc_calibrator
  import dcbc_pkg::*;
#(
  parameter int N_RAW = 32,
  parameter int N_OUT = 32,
  parameter int CNT_W = 12,
  localparam int AW   = $clog2(N_RAW),
  localparam int OB_W = $clog2(N_OUT),
  localparam int NE_W = OB_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start,
  input  logic             merge_mode,
  output logic             cal_busy,
  output logic             cal_done,
  output logic [AW-1:0]    hist_addr,
  input  logic [CNT_W-1:0] hist_rdata,
  input  logic             code_valid,
  input  logic [AW-1:0]    code_in,
  output logic             bin_valid,
  output logic [OB_W-1:0]  bin_out
);

  // named internal events, also watched by the bound checker
  logic            scan_wr;
  logic [AW-1:0]   scan_idx;
  logic            scan_valid;
  logic [OB_W-1:0] scan_main;
  logic            scan_comp_valid;
  logic [OB_W-1:0] scan_comp;
  frac_t           scan_frac;
  logic [NE_W-1:0] neff_w;
  frac_t           dither;

  dcbc_table_builder #(.N_RAW(N_RAW), .N_OUT(N_OUT), .CNT_W(CNT_W)) u_build (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (cal_start),
    .merge         (merge_mode),
    .busy          (cal_busy),
    .done          (cal_done),
    .rd_addr       (hist_addr),
    .rd_data       (hist_rdata),
    .neff          (neff_w),
    .wr_en         (scan_wr),
    .wr_idx        (scan_idx),
    .wr_valid      (scan_valid),
    .wr_main       (scan_main),
    .wr_comp_valid (scan_comp_valid),
    .wr_comp       (scan_comp),
    .wr_frac       (scan_frac)
  );

  dcbc_lfsr u_dither (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (code_valid),
    .value (dither)
  );

  dcbc_remap #(.N_RAW(N_RAW), .N_OUT(N_OUT)) u_remap (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (scan_wr),
    .wr_idx        (scan_idx),
    .wr_valid      (scan_valid),
    .wr_main       (scan_main),
    .wr_comp_valid (scan_comp_valid),
    .wr_comp       (scan_comp),
    .wr_frac       (scan_frac),
    .dither        (dither),
    .code_valid    (code_valid),
    .code_in       (code_in),
    .bin_valid     (bin_valid),
    .bin_out       (bin_out)
  );

endmodule

// File: rtl/dcbc_calibrator_chk.sv
module dcbc_calibrator_chk #(
  parameter int AW   = 5,
  parameter int OB_W = 5,
  parameter int NE_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cal_busy,
  input logic            cal_done,
  input logic [AW-1:0]   hist_addr,
  input logic            code_valid,
  input logic            bin_valid,
  input logic [OB_W-1:0] bin_out,
  input logic [NE_W-1:0] neff_w,
  input logic            scan_wr,
  input logic            scan_valid,
  input logic [OB_W-1:0] scan_main
);

  logic            have_prev;
  logic [OB_W-1:0] last_main;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      last_main <= '0;
    end else if (!scan_wr) begin
      have_prev <= 1'b0;
    end else if (scan_valid) begin
      have_prev <= 1'b1;
      last_main <= scan_main;
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_busy && cal_done)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && $past(cal_busy) && hist_addr != '0) |-> hist_addr == $past(hist_addr) + AW'(1)); // R2

  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid |-> $past(code_valid)); // R9

  AST_BIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_valid && cal_done) |-> {1'b0, bin_out} < neff_w); // R7

  AST_MAIN_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_wr && scan_valid && have_prev) |-> scan_main >= last_main); // R3

endmodule

bind dcbc_calibrator dcbc_calibrator_chk #(.AW(AW), .OB_W(OB_W), .NE_W(NE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cal_busy   (cal_busy),
  .cal_done   (cal_done),
  .hist_addr  (hist_addr),
  .code_valid (code_valid),
  .bin_valid  (bin_valid),
  .bin_out    (bin_out),
  .neff_w     (neff_w),
  .scan_wr    (scan_wr),
  .scan_valid (scan_valid),
  .scan_main  (scan_main)
);

// File: tb/dcbc_calibrator_test.sv
module dcbc_calibrator_test;

  localparam int N     = 16;
  localparam int NO    = 16;
  localparam int CW    = 12;
  localparam int AW    = 4;
  localparam int OW    = 4;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_start = 1'b0;
  logic          merge_mode = 1'b0;
  logic          cal_busy, cal_done;
  logic [AW-1:0] hist_addr;
  logic [CW-1:0] hist_rdata;
  logic          code_valid = 1'b0;
  logic [AW-1:0] code_in = '0;
  logic          bin_valid;
  logic [OW-1:0] bin_out;

  int  hist [N];
  int  obs  [NO];
  int  checks = 0;
  int  errors = 0;
  int  mlfsr = 32'hACE1;
  bit  loaded = 0;
  bit  cur_merge = 0;

  always #(CLK_P / 2) clk = ~clk;
  assign hist_rdata = CW'(hist[hist_addr]);

  dcbc_calibrator #(.N_RAW(N), .N_OUT(NO), .CNT_W(CW)) uut (.*);

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_sim();
  end

  function automatic int dither_next(int s);
    int r;
    r = s / 2;
    if (s % 2 == 1) r = r ^ 32'hB400;
    return r;
  endfunction

  task automatic exp_entry(int k, bit mg, output bit v, output bit cv,
                           output int m, output int c, output int fr);
    longint tot, lo, hi, e, b;
    tot = 0; lo = 0;
    for (int i = 0; i < N; i++) begin
      tot += hist[i];
      if (i < k) lo += hist[i];
    end
    hi = lo + hist[k];
    e  = mg ? NO / 2 : NO;
    v  = loaded && hist[k] != 0;
    m = 0; c = 0; fr = 0; cv = 0;
    if (v) begin
      m  = int'((lo * e) / tot);
      b  = (m + 1) * tot;
      cv = (hi * e) > b;
      c  = m + 1;
      if (cv) fr = int'(((hi * e - b) * 65536) / (hist[k] * e));
    end
  endtask

  task automatic send(int k);
    bit v, cv; int m, c, fr, eb; string tag;
    exp_entry(k, cur_merge, v, cv, m, c, fr);
    eb = (cv && mlfsr < fr) ? c : m;
    code_valid = 1'b1;
    code_in    = AW'(k);
    mlfsr      = dither_next(mlfsr);
    @(negedge clk);
    if (!loaded)        tag = "R1";
    else if (!v)        tag = "R6";
    else if (cur_merge) tag = "R7";
    else if (cv)        tag = "R5/R8";
    else                tag = "R3/R4";
    chk(bin_valid == v, {tag, " valid"}, bin_valid, v);
    if (v && bin_valid) begin
      chk(bin_out == OW'(eb), {tag, " bin"}, bin_out, eb);
      obs[bin_out]++;
    end
    code_valid = 1'b0;
  endtask

  task automatic calibrate(bit mg, bit poke);
    int cnt;
    @(negedge clk);
    cal_start = 1'b1; merge_mode = mg;
    @(negedge clk);
    cal_start = 1'b0; merge_mode = 1'b0;
    chk(cal_busy == 1'b1, "R2 busy after start", cal_busy, 1);
    cnt = 0;
    while (!cal_done && cnt < 1000) begin
      if (poke && cnt == 5) cal_start = 1'b1;
      else                  cal_start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    cal_start = 1'b0;
    chk(cnt == 2 * N, poke ? "R10 done timing with restart" : "R2 done timing", cnt, 2 * N);
    chk(cal_busy == 1'b0, "R2 busy cleared", cal_busy, 0);
    loaded = 1; cur_merge = mg;
  endtask

  task automatic sweep(int reps);
    for (int r = 0; r < reps; r++)
      for (int k = 0; k < N; k++) send(k);
  endtask

  initial begin
    int d [N] = '{100,100,0,300,50,50,100,100,0,20,180,100,100,200,100,100};
    int imax, imin, omax, omin;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cal_done == 1'b0, "R1 done after reset", cal_done, 0);
    chk(cal_busy == 1'b0, "R1 busy after reset", cal_busy, 0);
    for (int i = 0; i < N; i++) hist[i] = d[i];
    send(3);
    send(7);
    @(negedge clk);
    chk(bin_valid == 1'b0, "R9 idle output", bin_valid, 0);

    // directed table: ideal width 100, includes empty and triple-width bins
    calibrate(0, 0);
    sweep(6);
    @(negedge clk);
    chk(bin_valid == 1'b0, "R9 idle output", bin_valid, 0);
    // exact-boundary bin 12 never moves (R4), bin 3 gets 2/3 to comp (R5)
    calibrate(0, 1);
    sweep(2);

    // paired ideal bins
    calibrate(1, 0);
    sweep(4);
    chk(cal_done == 1'b1, "R2 done holds", cal_done, 1);

    // flatness replay on the directed histogram
    calibrate(0, 0);
    for (int b = 0; b < NO; b++) obs[b] = 0;
    for (int k = 0; k < N; k++)
      for (int j = 0; j < hist[k] / 2; j++) send(k);
    imax = 0; imin = 1 << 30; omax = 0; omin = 1 << 30;
    for (int k = 0; k < N; k++) begin
      if (hist[k] / 2 > imax) imax = hist[k] / 2;
      if (hist[k] / 2 < imin) imin = hist[k] / 2;
    end
    for (int b = 0; b < NO; b++) begin
      if (obs[b] > omax) omax = obs[b];
      if (obs[b] < omin) omin = obs[b];
    end
    chk((omax - omin) < (imax - imin), "R11 output spread", omax - omin, imax - imin);

    // seeded random histograms
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < N; i++)
        hist[i] = ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 400));
      hist[$urandom_range(0, N - 1)] = 900;
      calibrate(r[0], 0);
      sweep(5);
    end

    @(negedge clk);
    finish_sim();
  end

endmodule